// File: doc/BRIEF.md
# Flash Chip Erase Sequencer

This block runs a whole-array erase on a byte-wide flash device from the host side of a simple parallel bus. The bus has an address, write data, read data, a write strobe and a read strobe. After a start pulse the sequencer waits until the programming supply is reported good. It then writes the erase command byte twice. The first write arms the erase and the second write launches it.

While the device erases internally, the sequencer reads it over and over and watches one status bit. A poll budget bounds this wait. Once the status bit reports completion, the sequencer reads every byte of the array in ascending address order and expects the erased value in each one. The result is a one-cycle done pulse together with two error flags and the address of the first byte that failed. The host may return to ordinary reads only when both flags are clear.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `busy`, `done`, `bus_we`, `bus_re`, `err_timeout` and `err_verify` are all 0.
- R2: After `start`, no write strobe is issued until `vpp_ok` has been seen high. `busy` stays high while the block waits.
- R3: Exactly two bus writes are issued, in order, and both carry data 30h at address 0. The first write arms the erase and the second write starts it.
- R4: Each write holds `bus_we` high for exactly WR_PULSE cycles. The write data equals 30h in the cycle before the strobe rises and in the cycle after it falls.
- R5: After the second write, the block reads address 0 repeatedly. The first read whose bit 7 equals 1 ends the polling phase.
- R6: When POLL_MAX polling reads in a row return bit 7 equal to 0, the sequence ends with `err_timeout`=1 and performs no verify reads.
- R7: The verify scan reads addresses 0 to ARRAY_SIZE-1 in ascending order. Each read holds `bus_re` high for exactly RD_PULSE cycles with the address stable.
- R8: The scan stops at the first byte that differs from FFh. It sets `err_verify`=1 and drives that byte's address on `fail_addr`.
- R9: When every byte reads FFh, the sequence ends with both error flags at 0.
- R10: `done` is high for exactly one cycle per sequence, while `busy` is high, and `busy` falls in the following cycle. The error flags and `fail_addr` hold their values until the next start.
- R11: A `start` pulse while `busy` is high is ignored. The running sequence issues no additional writes and produces one `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| vpp_ok | input | 1 | Programming supply has reached its high level |
| bus_addr | output | ADDR_W | Flash address |
| bus_wdata | output | 8 | Flash write data |
| bus_rdata | input | 8 | Flash read data |
| bus_we | output | 1 | Write strobe, active high |
| bus_re | output | 1 | Read strobe, active high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err_timeout | output | 1 | Status bit 7 never reached 1 within the poll budget |
| err_verify | output | 1 | A byte of the array did not read FFh |
| fail_addr | output | ADDR_W | Address of the first byte that was not FFh |

## Verification
The device model stalls polling for a chosen number of reads and serves an array that can hold corrupted bytes. The stall count is varied across zero, a mid value, one short of the poll budget and the budget itself; these cases separate a correct timeout boundary from an off-by-one. Corrupted bytes at address 0, at the last address and at several addresses at once show whether the scan starts, ends and stops at the right place. A byte at address 0 that has bit 7 set but is not FFh separates the status test from the erased-value test. Random stall counts and corruption positions cover the mix, while a long supply delay and a second start pulse check the waiting and the rejection of a restart.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_SUPPLY,
      SEQ_ARM,
      SEQ_LAUNCH,
      SEQ_POLL,
      SEQ_SCAN,
      SEQ_END
   } seq_state_t;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LEAD,
      PH_STROBE,
      PH_TRAIL
   } bus_phase_t;

   localparam logic [7:0] ERASE_CMD   = 8'h30;
   localparam logic [7:0] ERASED_BYTE = 8'hFF;
   localparam int         STATUS_BIT  = 7;
endpackage

// File: rtl/flash_bus_engine.sv
module flash_bus_engine
   import flash_erase_pkg::*;
#(
   parameter int SETUP_CYC = 2,
   parameter int WR_PULSE  = 3,
   parameter int RD_PULSE  = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   input  logic       req_wr,
   input  logic [7:0] rdata_in,
   output logic       we,
   output logic       re,
   output logic       ack,
   output logic [7:0] rdata_q
);
   localparam int MAX_A   = (SETUP_CYC > WR_PULSE) ? SETUP_CYC : WR_PULSE;
   localparam int MAX_CYC = (MAX_A > RD_PULSE) ? MAX_A : RD_PULSE;
   localparam int CW      = $clog2(MAX_CYC + 1);

   bus_phase_t      phase;
   logic [CW-1:0]   cnt;
   logic            wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         cnt     <= '0;
         wr_q    <= 1'b0;
         ack     <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack <= 1'b0;
         unique case (phase)
            PH_IDLE: if (req) begin
               phase <= PH_LEAD;
               wr_q  <= req_wr;
               cnt   <= CW'(SETUP_CYC - 1);
            end
            PH_LEAD: if (cnt == '0) begin
               phase <= PH_STROBE;
               cnt   <= wr_q ? CW'(WR_PULSE - 1) : CW'(RD_PULSE - 1);
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_STROBE: if (cnt == '0) begin
               phase <= PH_TRAIL;
               cnt   <= CW'(SETUP_CYC - 1);
               if (!wr_q) rdata_q <= rdata_in;
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_TRAIL: if (cnt == '0) begin
               phase <= PH_IDLE;
               ack   <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   assign we = (phase == PH_STROBE) &&  wr_q;
   assign re = (phase == PH_STROBE) && !wr_q;
endmodule

// File: rtl/flash_poll_timer.sv
module flash_poll_timer #(
   parameter int POLL_MAX = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic last
);
   generate
      if (POLL_MAX == 0) begin : g_unbounded
         assign last = 1'b0;
      end else begin : g_bounded
         localparam int TW = (POLL_MAX < 2) ? 1 : $clog2(POLL_MAX);
         logic [TW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || clear) cnt <= '0;
            else if (tick)       cnt <= cnt + 1'b1;
         end
         assign last = (cnt == TW'(POLL_MAX - 1));
      end
   endgenerate
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
   import flash_erase_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int ARRAY_SIZE = 1 << ADDR_W,
   parameter int SETUP_CYC  = 2,
   parameter int WR_PULSE   = 3,
   parameter int RD_PULSE   = 2,
   parameter int POLL_MAX   = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              vpp_ok,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic [7:0]        bus_rdata,
   output logic              bus_we,
   output logic              bus_re,
   output logic              busy,
   output logic              done,
   output logic              err_timeout,
   output logic              err_verify,
   output logic [ADDR_W-1:0] fail_addr
);
   localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(ARRAY_SIZE - 1);

   generate
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("SETUP_CYC must be at least 1");
      end
      if (WR_PULSE < 1 || RD_PULSE < 1) begin : g_bad_pulse
         $error("strobe widths must be at least 1");
      end
      if (ARRAY_SIZE < 1 || ARRAY_SIZE > (1 << ADDR_W)) begin : g_bad_size
         $error("ARRAY_SIZE must fit in ADDR_W bits");
      end
      if (POLL_MAX < 0) begin : g_bad_poll
         $error("POLL_MAX must not be negative");
      end
   endgenerate

   seq_state_t        state;
   logic              inflight;
   logic              req;
   logic              req_wr;
   logic              ack;
   logic [7:0]        rd_q;
   logic              poll_last;
   logic              poll_tick;
   logic [ADDR_W-1:0] addr_q;

   assign req_wr = (state == SEQ_ARM) || (state == SEQ_LAUNCH);
   assign req    = !inflight && (req_wr || state == SEQ_POLL || state == SEQ_SCAN);
   assign poll_tick = (state == SEQ_POLL) && ack && !rd_q[STATUS_BIT];

   flash_bus_engine #(
      .SETUP_CYC (SETUP_CYC),
      .WR_PULSE  (WR_PULSE),
      .RD_PULSE  (RD_PULSE)
   ) i_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .req_wr   (req_wr),
      .rdata_in (bus_rdata),
      .we       (bus_we),
      .re       (bus_re),
      .ack      (ack),
      .rdata_q  (rd_q)
   );

   flash_poll_timer #(
      .POLL_MAX (POLL_MAX)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state != SEQ_POLL),
      .tick  (poll_tick),
      .last  (poll_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= SEQ_IDLE;
         inflight    <= 1'b0;
         addr_q      <= '0;
         err_timeout <= 1'b0;
         err_verify  <= 1'b0;
         fail_addr   <= '0;
      end else begin
         if (req)      inflight <= 1'b1;
         else if (ack) inflight <= 1'b0;
         unique case (state)
            SEQ_IDLE: if (start) begin
               state       <= SEQ_SUPPLY;
               addr_q      <= '0;
               err_timeout <= 1'b0;
               err_verify  <= 1'b0;
               fail_addr   <= '0;
            end
            SEQ_SUPPLY: if (vpp_ok) state <= SEQ_ARM;
            SEQ_ARM:    if (ack) state <= SEQ_LAUNCH;
            SEQ_LAUNCH: if (ack) state <= SEQ_POLL;
            SEQ_POLL: if (ack) begin
               if (rd_q[STATUS_BIT]) begin
                  state  <= SEQ_SCAN;
                  addr_q <= '0;
               end else if (poll_last) begin
                  err_timeout <= 1'b1;
                  state       <= SEQ_END;
               end
            end
            SEQ_SCAN: if (ack) begin
               if (rd_q != ERASED_BYTE) begin
                  err_verify <= 1'b1;
                  fail_addr  <= addr_q;
                  state      <= SEQ_END;
               end else if (addr_q == LAST_ADDR) begin
                  state <= SEQ_END;
               end else begin
                  addr_q <= addr_q + 1'b1;
               end
            end
            SEQ_END: state <= SEQ_IDLE;
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign bus_addr  = addr_q;
   assign bus_wdata = req_wr ? ERASE_CMD : 8'h00;
   assign busy      = (state != SEQ_IDLE);
   assign done      = (state == SEQ_END);
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       vpp_ok,
   input logic [7:0] bus_wdata,
   input logic       bus_we,
   input logic       bus_re,
   input logic       busy,
   input logic       done,
   input logic       err_timeout,
   input logic       err_verify
);
   logic supply_seen;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) supply_seen <= 1'b0;
      else if (vpp_ok)     supply_seen <= 1'b1;
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_we && !bus_re && !done));

   assert_no_early_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> supply_seen);

   assert_cmd_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> (bus_wdata == 8'h30));

   assert_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_we) |-> $stable(bus_wdata));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_we) |-> $stable(bus_wdata));

   assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && bus_re));

   assert_one_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_timeout && err_verify));

   assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
endmodule

bind flash_erase_seq flash_erase_seq_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .vpp_ok      (vpp_ok),
   .bus_wdata   (bus_wdata),
   .bus_we      (bus_we),
   .bus_re      (bus_re),
   .busy        (busy),
   .done        (done),
   .err_timeout (err_timeout),
   .err_verify  (err_verify)
);

// File: tb/test_flash_erase_seq.sv
module test_flash_erase_seq;
   localparam int AW = 5;
   localparam int SZ = 32;
   localparam int SU = 2;
   localparam int WP = 3;
   localparam int RP = 2;
   localparam int PM = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          vpp_ok = 1'b0;
   logic [AW-1:0] bus_addr;
   logic [7:0]    bus_wdata;
   logic [7:0]    bus_rdata;
   logic          bus_we, bus_re, busy, done, err_timeout, err_verify;
   logic [AW-1:0] fail_addr;

   always #4 clk = ~clk;

   flash_erase_seq #(
      .ADDR_W (AW), .ARRAY_SIZE (SZ), .SETUP_CYC (SU),
      .WR_PULSE (WP), .RD_PULSE (RP), .POLL_MAX (PM)
   ) i_flash_erase_seq (
      .clk (clk), .rst_n (rst_n), .start (start), .vpp_ok (vpp_ok),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .bus_we (bus_we), .bus_re (bus_re), .busy (busy), .done (done),
      .err_timeout (err_timeout), .err_verify (err_verify), .fail_addr (fail_addr)
   );

   int total = 0;
   int fails = 0;
   int cycles = 0;

   logic [7:0] mem [SZ];
   int stall = 0;
   int rd_cnt = 0;
   int exp_poll = 0;

   always_comb begin
      if (!bus_re)            bus_rdata = 8'h00;
      else if (rd_cnt < stall) bus_rdata = 8'h00;
      else                    bus_rdata = mem[bus_addr];
   end

   // monitor state
   int wr_cnt, wr_bad, vpp_bad, rd_bad, done_cnt, done_bad, we_len, re_len;
   logic we_p = 1'b0, re_p = 1'b0, done_p = 1'b0;
   logic [7:0] wd_p = 8'h00;
   logic [AW-1:0] addr_p = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (bus_we) begin
         if (!we_p && wd_p != 8'h30) wr_bad++;
         if (bus_wdata != 8'h30) wr_bad++;
         if (!vpp_ok) vpp_bad++;
         we_len++;
      end else if (we_p) begin
         wr_cnt++;
         if (we_len != WP) wr_bad++;
         if (bus_wdata != 8'h30) wr_bad++;
         we_len = 0;
      end
      if (bus_re) begin
         if (re_p && bus_addr != addr_p) rd_bad++;
         re_len++;
      end else if (re_p) begin
         if (re_len != RP) rd_bad++;
         if (rd_cnt < exp_poll) begin
            if (addr_p != '0) rd_bad++;
         end else if (int'(addr_p) != rd_cnt - exp_poll) begin
            rd_bad++;
         end
         rd_cnt++;
         re_len = 0;
      end
      if (done) begin
         done_cnt++;
         if (!busy) done_bad++;
      end
      if (done_p && busy) done_bad++;
      we_p = bus_we; re_p = bus_re; done_p = done;
      wd_p = bus_wdata; addr_p = bus_addr;
   end

   task automatic fill_erased();
      for (int i = 0; i < SZ; i++) mem[i] = 8'hFF;
   endtask

   task automatic run_case(input string name, input int bp, input int vd,
                           input bit restart);
      int exp_reads, guard, first_bad;
      bit exp_to, exp_ve;
      exp_to = 0; exp_ve = 0; first_bad = 0;
      if (bp >= PM || !mem[0][7]) begin
         exp_to = 1; exp_poll = PM; exp_reads = PM;
      end else begin
         exp_poll = bp + 1;
         exp_reads = exp_poll + SZ;
         for (int i = SZ - 1; i >= 0; i--)
            if (mem[i] != 8'hFF) first_bad = i;
         for (int i = 0; i < SZ; i++)
            if (mem[i] != 8'hFF && !exp_ve) begin
               exp_ve = 1; exp_reads = exp_poll + i + 1;
            end
      end
      stall = bp; rd_cnt = 0;
      wr_cnt = 0; wr_bad = 0; vpp_bad = 0; rd_bad = 0;
      done_cnt = 0; done_bad = 0; we_len = 0; re_len = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (vd) @(negedge clk);
      chk(busy == 1'b1, "R2", {name, " busy while waiting for supply"}, busy, 1);
      vpp_ok = 1'b1;
      if (restart) begin
         repeat (15) @(negedge clk);
         start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      guard = 0;
      while (done_cnt == 0 && guard < 5000) begin
         @(negedge clk); guard++;
      end
      repeat (3) @(negedge clk);
      vpp_ok = 1'b0;
      chk(vpp_bad == 0, "R2", {name, " write before supply"}, vpp_bad, 0);
      chk(wr_cnt == 2, "R3", {name, " command writes"}, wr_cnt, 2);
      chk(wr_bad == 0, "R4", {name, " write width/setup/hold errors"}, wr_bad, 0);
      chk(err_timeout == exp_to, "R6", {name, " timeout flag"}, err_timeout, exp_to);
      chk(rd_cnt == exp_reads, "R5", {name, " read count"}, rd_cnt, exp_reads);
      chk(rd_bad == 0, "R7", {name, " read address/width errors"}, rd_bad, 0);
      chk(err_verify == exp_ve, "R8", {name, " verify flag"}, err_verify, exp_ve);
      if (exp_ve)
         chk(fail_addr == AW'(first_bad), "R8", {name, " fail address"},
             fail_addr, first_bad);
      if (!exp_to && !exp_ve)
         chk(!err_timeout && !err_verify, "R9", {name, " clean finish"},
             err_timeout + err_verify, 0);
      chk(done_cnt == 1 && done_bad == 0, restart ? "R11" : "R10",
          {name, " single done pulse"}, done_cnt, 1);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      fill_erased();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !bus_we && !bus_re && !err_timeout && !err_verify,
          "R1", "reset state", {busy, done, bus_we, bus_re, err_timeout, err_verify}, 0);

      run_case("immediate", 0, 0, 0);
      run_case("long supply ramp", 5, 40, 0);
      run_case("poll budget minus one", PM - 1, 2, 0);
      run_case("poll budget reached", PM, 2, 0);
      chk(err_timeout == 1'b1, "R10", "flag held after done", err_timeout, 1);
      run_case("stall far beyond budget", PM + 7, 0, 0);
      mem[SZ-1] = 8'hFE;
      run_case("bad last byte", 3, 1, 0);
      fill_erased();
      mem[0] = 8'h80;
      run_case("status set, byte not erased", 2, 0, 0);
      fill_erased();
      mem[3] = 8'h7F; mem[9] = 8'h00;
      run_case("two bad bytes", 1, 0, 0);
      fill_erased();
      mem[0] = 8'h7F;
      run_case("status never set", 0, 0, 0);
      fill_erased();
      run_case("restart ignored", 4, 3, 1);

      for (int k = 0; k < 8; k++) begin
         fill_erased();
         if ($urandom_range(0, 2) != 0)
            mem[$urandom_range(0, SZ - 1)] = 8'($urandom_range(0, 254));
         run_case($sformatf("random %0d", k), $urandom_range(0, PM + 4),
                  $urandom_range(0, 10), 0);
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      wait (cycles > 150000);
      total++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule